// File: doc/BRIEF.md
# Offset Calibration Sequencer for a Two-Channel Sample Stream

This block runs the start-up offset calibration of a two-channel audio sample path. While its reset input is high, the path is idle and the busy flag is up. When reset is released, the block counts word-clock ticks for a calibration window. The length of that window depends on the speed mode and on whether the interface is the clock master or a slave. Near the end of the window it measures a DC offset for each channel. After the window it subtracts that offset from every sample that passes through, and it clamps each result to the signed 24-bit range.

The measured offset comes either from the live input samples or from a common-mode reference sample path. A select input chooses between the two. Output data are held at zero until a separate, later point in the count, where the output-valid flag rises. After that, every incoming sample produces a corrected sample one clock later.

Top module: `offset_cal_seq`

## Requirements
- R1: While `rst` is high, at each clock edge `busy` is set to 1, and `valid`, `out_stb` and `out_data` are cleared to 0. Sample strobes during reset produce no output.
- R2: After reset release in normal speed (`speed_dbl`=0) and master mode (`is_slave`=0), `busy` stays 1 until the clock edge that accepts the 8704th `tick`, and is 0 after that edge. In double speed (`speed_dbl`=1) the count is 17408.
- R3: `valid` rises at the clock edge that accepts the 8960th `tick` in normal speed, or the 17920th in double speed. While `valid` is 1, `busy` is 0.
- R4: With `is_slave`=1, both counts in R2 and R3 are one tick larger.
- R5: `speed_dbl` and `is_slave` are captured while `rst` is high. Changes to them after release have no effect until the next reset.
- R6: For each channel, the offset is the floor mean (sum shifted arithmetically right by 4) of the first 16 samples of that channel that arrive while `busy` is 1 and at least (calibration count − 64) ticks have been accepted. Samples outside that window, and samples after the 16th, are ignored. The offset is then frozen until the next reset.
- R7: When `ref_sel`=1, the measured value is `smp_raw`. When `ref_sel`=0, it is `smp_ref`, and `smp_raw` does not affect the offset.
- R8: Once `valid` is 1, a strobe on `smp_stb` produces, one clock later, `out_stb`=1, `out_ch`=`smp_ch` and `out_data` = `smp_raw` minus the offset of that channel. Channel code 0 is left and 1 is right. With no strobe, `out_stb` is 0 in the next cycle.
- R9: The subtraction is performed at 25 bits. A result above 0x7FFFFF gives 0x7FFFFF, and a result below −0x800000 gives 0x800000.
- R10: Out of reset but before `valid`, a strobe still gives `out_stb`=1 one clock later, with `out_data`=0.
- R11: Once `busy` has fallen it stays 0, and once `valid` has risen it stays 1, until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; its release starts calibration |
| speed_dbl | input | 1 | Speed mode: 0 normal, 1 double (captured in reset) |
| is_slave | input | 1 | 1 when the serial interface is a slave (captured in reset) |
| tick | input | 1 | One-cycle pulse per word-clock rising edge |
| ref_sel | input | 1 | 1 measures the live input, 0 the common-mode reference |
| smp_stb | input | 1 | Sample strobe |
| smp_ch | input | 1 | Channel of the sample (0 left, 1 right) |
| smp_raw | input | 24 | Live signed sample |
| smp_ref | input | 24 | Signed sample from the common-mode reference path |
| out_stb | output | 1 | Corrected sample strobe |
| out_ch | output | 1 | Channel of the corrected sample |
| out_data | output | 24 | Corrected, clamped signed sample |
| busy | output | 1 | Calibration in progress |
| valid | output | 1 | Output data valid |

## Verification
The assertions check on every cycle the properties that hold at all times:
- the reset values of the outputs;
- that `busy` and `valid` never fall back;
- that `valid` excludes `busy`;
- that the captured mode is held outside reset;
- that a finished offset stays frozen;
- that strobes pass through with one cycle of latency, with zero data before `valid`.

Only the bench scenarios can show the rest:
- the exact tick counts for all four combinations of speed and master/slave, with the mode pins flipped after release;
- the value of the per-channel mean under each reference selection;
- the clamping at both ends of the range with large offsets.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef struct packed {
    logic dbl;
    logic slv;
  } cal_mode_t;
endpackage

// File: rtl/cal_timer.sv
module cal_timer
  import cal_pkg::*;
#(
  parameter int CAL_NORM   = 8704,
  parameter int VALID_NORM = 8960,
  parameter int WIN        = 64,
  parameter int CNT_W      = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  cal_mode_t mode_in,
  output logic      busy,
  output logic      valid,
  output logic      in_win
);
  localparam logic [CNT_W-1:0] CAL1 = CNT_W'(CAL_NORM);
  localparam logic [CNT_W-1:0] CAL2 = CNT_W'(2 * CAL_NORM);
  localparam logic [CNT_W-1:0] VLD1 = CNT_W'(VALID_NORM);
  localparam logic [CNT_W-1:0] VLD2 = CNT_W'(2 * VALID_NORM);
  localparam logic [CNT_W-1:0] WINC = CNT_W'(WIN);

  cal_mode_t        mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] cal_len;
  logic [CNT_W-1:0] vld_len;
  logic             busy_q;
  logic             valid_q;
  logic             run_q;

  always_comb begin
    cal_len = (mode_q.dbl ? CAL2 : CAL1) + {{(CNT_W-1){1'b0}}, mode_q.slv};
    vld_len = (mode_q.dbl ? VLD2 : VLD1) + {{(CNT_W-1){1'b0}}, mode_q.slv};
    cnt_inc = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= mode_in;
      cnt_q   <= '0;
      busy_q  <= 1'b1;
      valid_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (tick && !valid_q) begin
        cnt_q <= cnt_inc;
        if (cnt_inc == cal_len) busy_q  <= 1'b0;
        if (cnt_inc == vld_len) valid_q <= 1'b1;
      end
    end
  end

  assign busy   = busy_q;
  assign valid  = valid_q;
  assign in_win = busy_q && (cnt_q >= cal_len - WINC);

  // R11
  busy_fall_only_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |=> !busy_q);
  // R11
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> valid_q);
  // R3
  valid_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> !busy_q);
  // R5
  mode_stable_chk: assert property (@(posedge clk) disable iff (rst)
    run_q |=> $stable(mode_q));
endmodule

// File: rtl/cal_offset_acc.sv
module cal_offset_acc #(
  parameter int DW       = 24,
  parameter int AVG_LOG2 = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [DW-1:0] sample,
  output logic [DW-1:0] offset
);
  localparam int ACC_W = DW + AVG_LOG2;
  localparam int N_W   = AVG_LOG2 + 1;
  localparam logic [N_W-1:0] N_LAST = N_W'(1 << AVG_LOG2);

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_nx;
  logic signed [ACC_W-1:0] mean;
  logic        [N_W-1:0]   n_q;
  logic                    done_q;
  logic        [DW-1:0]    off_q;

  always_comb begin
    acc_nx = acc_q + ACC_W'($signed(sample));
    mean   = acc_nx >>> AVG_LOG2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      n_q    <= '0;
      done_q <= 1'b0;
      off_q  <= '0;
    end else if (take && !done_q) begin
      acc_q <= acc_nx;
      n_q   <= n_q + 1'b1;
      if (n_q + 1'b1 == N_LAST) begin
        done_q <= 1'b1;
        off_q  <= mean[DW-1:0];
      end
    end
  end

  assign offset = off_q;

  // R6
  offset_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> $stable(off_q));
  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    n_q <= N_LAST);
endmodule

// File: rtl/cal_corrector.sv
module cal_corrector #(
  parameter int DW   = 24,
  parameter int CH_W = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stb,
  input  logic [CH_W-1:0] ch,
  input  logic [DW-1:0]   raw,
  input  logic [DW-1:0]   off,
  input  logic            valid,
  output logic            out_stb,
  output logic [CH_W-1:0] out_ch,
  output logic [DW-1:0]   out_data
);
  localparam int SW = DW + 1;
  localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};

  logic signed [SW-1:0] diff;
  logic        [DW-1:0] clamped;
  logic                 stb_q;
  logic [CH_W-1:0]      ch_q;
  logic [DW-1:0]        data_q;

  always_comb begin
    diff = $signed({raw[DW-1], raw}) - $signed({off[DW-1], off});
    if (diff[SW-1] != diff[SW-2])
      clamped = diff[SW-1] ? NEG_MIN : POS_MAX;
    else
      clamped = diff[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q  <= 1'b0;
      ch_q   <= '0;
      data_q <= '0;
    end else begin
      stb_q <= stb;
      if (stb) begin
        ch_q   <= ch;
        data_q <= valid ? clamped : '0;
      end
    end
  end

  assign out_stb  = stb_q;
  assign out_ch   = ch_q;
  assign out_data = data_q;

  // R8
  stb_follow_chk: assert property (@(posedge clk) disable iff (rst)
    stb |=> (out_stb && out_ch == $past(ch)));
  // R8
  no_stb_chk: assert property (@(posedge clk) disable iff (rst)
    !stb |=> !out_stb);
  // R10
  zero_before_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (stb && !valid) |=> out_data == '0);
endmodule

// File: rtl/offset_cal_seq.sv
module offset_cal_seq
  import cal_pkg::*;
#(
  parameter int DW         = 24,
  parameter int NCH        = 2,
  parameter int CAL_NORM   = 8704,
  parameter int VALID_NORM = 8960,
  parameter int WIN        = 64,
  parameter int AVG_LOG2   = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   speed_dbl,
  input  logic                   is_slave,
  input  logic                   tick,
  input  logic                   ref_sel,
  input  logic                   smp_stb,
  input  logic [$clog2(NCH)-1:0] smp_ch,
  input  logic [DW-1:0]          smp_raw,
  input  logic [DW-1:0]          smp_ref,
  output logic                   out_stb,
  output logic [$clog2(NCH)-1:0] out_ch,
  output logic [DW-1:0]          out_data,
  output logic                   busy,
  output logic                   valid
);
  localparam int CH_W  = $clog2(NCH);
  localparam int CNT_W = $clog2(2 * VALID_NORM + 2) + 1;

  cal_mode_t     mode_in;
  logic          in_win;
  logic [DW-1:0] meas;
  logic [DW-1:0] offs [NCH];
  logic [DW-1:0] off_sel;

  assign mode_in = '{dbl: speed_dbl, slv: is_slave};
  assign meas    = ref_sel ? smp_raw : smp_ref;
  assign off_sel = offs[smp_ch];

  cal_timer #(
    .CAL_NORM(CAL_NORM), .VALID_NORM(VALID_NORM), .WIN(WIN), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst(rst), .tick(tick), .mode_in(mode_in),
    .busy(busy), .valid(valid), .in_win(in_win)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cal_offset_acc #(.DW(DW), .AVG_LOG2(AVG_LOG2)) u_acc (
      .clk(clk), .rst(rst),
      .take(smp_stb && in_win && (smp_ch == CH_W'(c))),
      .sample(meas), .offset(offs[c])
    );
  end

  cal_corrector #(.DW(DW), .CH_W(CH_W)) u_corr (
    .clk(clk), .rst(rst), .stb(smp_stb), .ch(smp_ch), .raw(smp_raw),
    .off(off_sel), .valid(valid),
    .out_stb(out_stb), .out_ch(out_ch), .out_data(out_data)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (busy && !valid && !out_stb && out_data == '0));
endmodule

// File: tb/tb_offset_cal_seq.sv
module tb_offset_cal_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic speed_dbl = 1'b0, is_slave = 1'b0, tick = 1'b0, ref_sel = 1'b1;
  logic smp_stb = 1'b0;
  logic [0:0] smp_ch = '0;
  logic [23:0] smp_raw = '0, smp_ref = '0;
  logic out_stb, busy, valid;
  logic [0:0] out_ch;
  logic [23:0] out_data;

  int checks = 0, errors = 0, cyc = 0;
  longint acc [2];
  int     nacc [2];
  longint off [2];

  always #2 clk = ~clk;

  offset_cal_seq dut (
    .clk(clk), .rst(rst), .speed_dbl(speed_dbl), .is_slave(is_slave),
    .tick(tick), .ref_sel(ref_sel), .smp_stb(smp_stb), .smp_ch(smp_ch),
    .smp_raw(smp_raw), .smp_ref(smp_ref), .out_stb(out_stb),
    .out_ch(out_ch), .out_data(out_data), .busy(busy), .valid(valid)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=<190000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] sat24(input longint v);
    if (v > 64'sd8388607) return 24'h7FFFFF;
    if (v < -64'sd8388608) return 24'h800000;
    return v[23:0];
  endfunction

  function automatic longint sx(input logic [23:0] v);
    return longint'($signed(v));
  endfunction

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic send(input bit ch, input logic [23:0] raw, input logic [23:0] rf);
    @(negedge clk);
    smp_stb = 1'b1; smp_ch = ch; smp_raw = raw; smp_ref = rf;
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  task automatic run_case(input bit dbl, input bit slv, input bit rsel, input bit gaps, input int kind);
    int cal_len, vl;
    logic [23:0] raw, rf;
    cal_len = (dbl ? 17408 : 8704) + int'(slv);
    vl      = (dbl ? 17920 : 8960) + int'(slv);
    for (int c = 0; c < 2; c++) begin acc[c] = 0; nacc[c] = 0; off[c] = 0; end
    @(negedge clk);
    rst = 1'b1; speed_dbl = dbl; is_slave = slv; ref_sel = rsel;
    repeat (3) @(negedge clk);
    send(1'b0, 24'h123456, 24'h0);
    chk(busy == 1'b1, "R1 busy in reset", busy, 1);
    chk(valid == 1'b0 && out_stb == 1'b0 && out_data == 24'h0, "R1 idle outputs",
        {valid, out_stb, out_data}, 0);
    @(negedge clk) rst = 1'b0;
    speed_dbl = ~dbl; is_slave = ~slv;   // R5: must be ignored
    for (int n = 1; n <= vl + 2; n++) begin
      if (gaps && ($urandom % 2 == 1)) @(negedge clk);
      do_tick();
      chk(busy == (n < cal_len), slv ? "R4 R5 busy" : "R2 R5 busy", busy, n < cal_len);
      chk(valid == (n >= vl), slv ? "R4 R5 valid" : "R3 R5 valid", valid, n >= vl);
      if (n >= cal_len - 80 && n < cal_len) begin
        for (int c = 0; c < 2; c++) begin
          if (kind == 0) begin
            raw = 24'($urandom_range(0, 2097151) - 1048576);
            rf  = 24'($urandom);
          end else begin
            raw = 24'($urandom);
            rf  = (c == 0) ? 24'(32'h400000 + $urandom_range(0, 15))
                           : 24'(-32'sh400000 - $signed($urandom_range(0, 15)));
          end
          send(c[0], raw, rf);
          if (n >= cal_len - 64 && nacc[c] < 16) begin
            acc[c] += rsel ? sx(raw) : sx(rf);
            nacc[c]++;
            if (nacc[c] == 16) off[c] = acc[c] >>> 4;
          end
          chk(out_stb && out_data == 24'h0, "R10 zero in window", out_data, 0);
        end
      end
      if (n >= cal_len && n < vl && (n % 64 == 0)) begin
        send(1'b1, 24'h3FFFFF, 24'h0);
        chk(out_stb == 1'b1 && out_data == 24'h0, "R10 zero before valid", out_data, 0);
      end
    end
    for (int i = 0; i < 60; i++) begin
      bit c;
      c = i[0];
      raw = 24'($urandom);
      send(c, raw, 24'($urandom));
      chk(out_stb && out_ch == c && out_data == sat24(sx(raw) - off[c]),
          "R8 R6 R7 corrected", out_data, sat24(sx(raw) - off[c]));
      @(negedge clk);
      chk(out_stb == 1'b0, "R8 no strobe", out_stb, 0);
    end
    send(1'b0, 24'h800000, 24'h0);
    chk(out_data == sat24(-64'sd8388608 - off[0]), "R9 low end ch0", out_data,
        sat24(-64'sd8388608 - off[0]));
    send(1'b1, 24'h7FFFFF, 24'h0);
    chk(out_data == sat24(64'sd8388607 - off[1]), "R9 high end ch1", out_data,
        sat24(64'sd8388607 - off[1]));
    if (kind == 1) begin
      chk(out_data == 24'h7FFFFF, "R9 positive clamp", out_data, 24'h7FFFFF);
      send(1'b0, 24'h800000, 24'h0);
      chk(out_data == 24'h800000, "R9 negative clamp", out_data, 24'h800000);
    end
    chk(busy == 1'b0 && valid == 1'b1, "R11 flags held", {busy, valid}, 1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    run_case(1'b0, 1'b0, 1'b1, 1'b1, 0);
    run_case(1'b0, 1'b1, 1'b0, 1'b0, 1);
    run_case(1'b1, 1'b0, 1'b1, 1'b0, 0);
    run_case(1'b1, 1'b1, 1'b0, 1'b0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule